// File: doc/BRIEF.md
# Burst Word-Address Sequencer

This block produces the word addresses of a short memory burst. A load command
takes a full start address and the access direction; each later advance
command moves to the next word of a four-word group. Only the two lowest
address bits move, and the bits above them stay as loaded. A mode input picks
the order of the words. In linear order the words count upward and wrap around
inside the group. In interleaved order the low bits are the start bits XORed
with the beat number.

The controller issues one command per enabled clock edge on a single
advance/load line. A select input qualifies loads only, so an advance keeps
stepping a burst that was already started, whatever the select and write
inputs do. A hold input freezes every register. The address, the captured
direction and the beat number come out of registers. The only exception is the
order selection, which is applied to the registered start bits and beat
without a register.

Top module: `burst_seq_top`

## Requirements
- R1: While reset is asserted (rst_n low), beat_o is 0, addr_o is 0 and wr_o is 0.
- R2: At a clock edge with hold_i=0, adv_i=0 and sel_i=1 (a load), the start address is taken from addr_i and the direction from we_i (1 = write). After the edge beat_o is 0, addr_o equals the loaded address and wr_o equals the captured we_i, in either order.
- R3: At a clock edge with hold_i=0 and adv_i=1 (an advance), beat_o goes up by one modulo 4, so it passes from 3 back to 0 if advancing continues.
- R4: With mode_i=0 (linear), addr_o[1:0] equals (start[1:0] + beat_o) modulo 4.
- R5: With mode_i=1 (interleaved), addr_o[1:0] equals start[1:0] XOR beat_o.
- R6: addr_o bits above bit 1 keep the loaded value through every advance.
- R7: wr_o keeps the value captured at the load through every advance, whatever we_i is during the advances.
- R8: An advance takes effect whether sel_i is 0 or 1.
- R9: At a clock edge with hold_i=1, beat_o, wr_o and the start address keep their values, whether the edge carries a load or an advance.
- R10: A load command with sel_i=0 captures nothing: beat_o, wr_o and addr_o keep their values.
- R11: A change of mode_i changes the order of addr_o[1:0] for the current start and beat without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| hold_i | input | 1 | 1 freezes all state at this edge |
| adv_i | input | 1 | 1 = advance burst, 0 = load start address |
| sel_i | input | 1 | Select, qualifies loads only |
| we_i | input | 1 | Direction sampled at a load, 1 = write |
| mode_i | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_i | input | ADDR_W | Start address for a load |
| addr_o | output | ADDR_W | Current word address |
| wr_o | output | 1 | Direction captured at the burst start |
| beat_o | output | 2 | Position within the burst |

## Verification
The hold input can land on the same edge as either command. The bench raises
hold together with an advance part-way through every swept burst, and also
together with a load that carries a new address and direction. It then expects
the beat, the direction and the address to be the same as before that edge.
The sweep covers every start position, both directions and both orders, with
select and write inputs toggled during the advances. This shows that a
stepping burst ignores both of them.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;

endpackage

// File: rtl/burst_seq_start_reg.sv
module burst_seq_start_reg #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_in,
  output logic [ADDR_W-1:0] base_q,
  output logic              wr_q
);

  logic [ADDR_W-1:0] base_d;
  logic              wr_d;

  always_comb begin
    base_d = base_q;
    wr_d   = wr_q;
    if (capture) begin
      base_d = addr_in;
      wr_d   = wr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      base_q <= base_d;
      wr_q   <= wr_d;
    end
  end

endmodule

// File: rtl/burst_seq_beat_ctr.sv
module burst_seq_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q
);

  logic [BEAT_W-1:0] beat_d;

  always_comb begin
    beat_d = beat_q;
    if (clear) begin
      beat_d = '0;
    end else if (step) begin
      beat_d = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else begin
      beat_q <= beat_d;
    end
  end

endmodule

// File: rtl/burst_seq_low_map.sv
module burst_seq_low_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_e            order,
  input  logic [BEAT_W-1:0] start_low,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low
);

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] xor_low;

  assign lin_low = start_low + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
    assign xor_low[b] = start_low[b] ^ beat[b];
  end

  always_comb begin
    if (order == ORDER_INTERLEAVE) begin
      low = xor_low;
    end else begin
      low = lin_low;
    end
  end

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BURST_LEN = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         hold_i,
  input  logic                         adv_i,
  input  logic                         sel_i,
  input  logic                         we_i,
  input  logic                         mode_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic [ADDR_W-1:0]            addr_o,
  output logic                         wr_o,
  output logic [$clog2(BURST_LEN)-1:0] beat_o
);

  localparam int BEAT_W = $clog2(BURST_LEN);

  logic              load_en;
  logic              step_en;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_bits;
  order_e            order;

  assign load_en = !hold_i && !adv_i && sel_i;
  assign step_en = !hold_i && adv_i;
  assign order   = order_e'(mode_i);

  burst_seq_start_reg #(.ADDR_W(ADDR_W)) start_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (load_en),
    .addr_in (addr_i),
    .wr_in   (we_i),
    .base_q  (base_q),
    .wr_q    (wr_o)
  );

  burst_seq_beat_ctr #(.BEAT_W(BEAT_W)) beat_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (load_en),
    .step   (step_en),
    .beat_q (beat_q)
  );

  burst_seq_low_map #(.BEAT_W(BEAT_W)) map_i (
    .order     (order),
    .start_low (base_q[BEAT_W-1:0]),
    .beat      (beat_q),
    .low       (low_bits)
  );

  assign beat_o = beat_q;
  assign addr_o = {base_q[ADDR_W-1:BEAT_W], low_bits};

  // R2: a load restarts the burst at the supplied address and direction
  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !adv_i && sel_i) |=>
      (beat_o == '0) && (addr_o == $past(addr_i)) && (wr_o == $past(we_i)));

  // R3 / R8: an advance steps the beat by one whatever sel_i is
  a_r3_step_mod: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && adv_i) |=> beat_o == BEAT_W'($past(beat_o) + 1'b1));

  a_r8_step_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && adv_i && !sel_i) |=> beat_o != $past(beat_o));

  // R6: upper address bits fixed while stepping
  a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && adv_i) |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

  // R7: direction fixed while stepping
  a_r7_dir_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && adv_i) |=> $stable(wr_o));

  // R9: hold freezes all state
  a_r9_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(beat_o) && $stable(wr_o) &&
               $stable(addr_o[ADDR_W-1:BEAT_W]));

  // R10: an unselected load captures nothing
  a_r10_unsel_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !adv_i && !sel_i) |=> $stable(beat_o) && $stable(wr_o) &&
                                      $stable(addr_o[ADDR_W-1:BEAT_W]));

  // R1: reset state
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_state: assert (beat_q == '0 && base_q == '0);
    end
  end

endmodule

// File: tb/burst_seq_top_tb_top.sv
module burst_seq_top_tb_top;

  localparam int    ADDR_W = 20;
  localparam time   CLK_P  = 10ns;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              hold_i, adv_i, sel_i, we_i, mode_i;
  logic [ADDR_W-1:0] addr_i;
  logic [ADDR_W-1:0] addr_o;
  logic              wr_o;
  logic [1:0]        beat_o;

  int n_chk  = 0;
  int n_fail = 0;

  logic [ADDR_W-1:0] m_base;
  logic              m_wr;
  logic [1:0]        m_beat;

  always #(CLK_P/2) clk = ~clk;

  burst_seq_top #(.ADDR_W(ADDR_W), .BURST_LEN(4)) dut_i (
    .clk (clk), .rst_n (rst_n), .hold_i (hold_i), .adv_i (adv_i),
    .sel_i (sel_i), .we_i (we_i), .mode_i (mode_i), .addr_i (addr_i),
    .addr_o (addr_o), .wr_o (wr_o), .beat_o (beat_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_addr(input logic m);
    logic [1:0] lo;
    lo = m ? (m_base[1:0] ^ m_beat) : 2'((m_base[1:0] + m_beat) % 4);
    return {m_base[ADDR_W-1:2], lo};
  endfunction

  // apply one edge: inputs set at negedge, results sampled at following negedge
  task automatic cycle(input logic h, input logic a, input logic s,
                       input logic w, input logic [ADDR_W-1:0] ad);
    hold_i = h; adv_i = a; sel_i = s; we_i = w; addr_i = ad;
    @(negedge clk);
    if (!h) begin
      if (!a && s) begin
        m_base = ad; m_wr = w; m_beat = 2'd0;
      end else if (a) begin
        m_beat = m_beat + 2'd1;
      end
    end
  endtask

  task automatic check_all(input string req);
    chk(beat_o == m_beat, {req, " beat"}, beat_o, m_beat);
    chk(wr_o == m_wr, {req, " dir"}, wr_o, m_wr);
    chk(addr_o == exp_addr(mode_i), {req, " addr"}, addr_o, exp_addr(mode_i));
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hold_i = 0; adv_i = 0; sel_i = 0; we_i = 0; mode_i = 0;
    addr_i = '0;
    m_base = '0; m_wr = 0; m_beat = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(beat_o == 2'd0, "R1 beat", beat_o, 0);
    chk(addr_o == '0, "R1 addr", addr_o, 0);
    chk(wr_o == 1'b0, "R1 dir", wr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int w = 0; w < 2; w++) begin
          logic [ADDR_W-1:0] ad;
          ad = ADDR_W'((m * 8 + s * 2 + w) * 37 + 'h5A000) & ~ADDR_W'(3) | ADDR_W'(s);
          mode_i = m[0];
          cycle(0, 0, 1, w[0], ad);
          check_all("R2 load");
          for (int k = 0; k < 6; k++) begin
            // R8: sel toggles, R7: we opposite of captured
            cycle(0, 1, k[0], ~w[0], ~ad);
            check_all(m ? "R5/R3/R6/R7/R8 interleave" : "R4/R3/R6/R7/R8 linear");
            if (k == 2) begin
              cycle(1, 1, 1, ~w[0], '0);
              check_all("R9 hold on advance");
            end
          end
        end
      end
    end

    // R9: hold on a load
    mode_i = 0;
    cycle(0, 0, 1, 1'b1, ADDR_W'('h12345));
    cycle(0, 1, 1, 1'b0, '0);
    cycle(1, 0, 1, 1'b0, ADDR_W'('hABCDE));
    check_all("R9 hold on load");

    // R10: unselected load ignored
    cycle(0, 0, 0, 1'b0, ADDR_W'('h0F0F0));
    check_all("R10 unselected load");
    chk(beat_o == 2'd1, "R10 beat kept", beat_o, 1);

    // R11: mode change reorders without an edge (start low=3, beat=1)
    cycle(0, 0, 1, 1'b0, ADDR_W'('h00013));
    cycle(0, 1, 0, 1'b0, '0);
    mode_i = 0; #1;
    chk(addr_o[1:0] == 2'd0, "R11 linear", addr_o[1:0], 0);
    mode_i = 1; #1;
    chk(addr_o[1:0] == 2'd2, "R11 interleave", addr_o[1:0], 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule